// File: doc/BRIEF.md
# Bad-Block-Skipping NAND Image Loader

This sequencer copies an image of a given byte length out of NAND flash into a destination memory, one 2048-byte page at a time. A page-read engine does the flash access and error correction; the loader only tells it which page to fetch and where the page belongs in memory. It then looks at the outcome of each read to decide what to do with the block that holds the page.

Pages are grouped into blocks of 64, counted from the start page. Each block ends up in one of three classes:

- **Good**: its pages are kept, and the destination moves forward by one block.
- **Marked bad**: a successfully read page carries a non-erased marker in its spare area. The block is skipped.
- **Fully unreadable**: no read in the block succeeded. It is treated as bad and skipped.

A read failure inside a block that is otherwise good stops the whole load with an error.

A skipped block does not advance the destination. Its data is therefore overwritten by the next block that is tried.

Top module: `nand_image_loader`

## Requirements
- R1: After reset, `rd_req`, `done` and `error` are all low.
- R2: The first page requested is the start byte offset shifted right by 11, so the low 11 offset bits are dropped. Its destination is `dest_base`.
- R3: The load covers ceil(len/2048) pages in ceil(len/131072) blocks. Pages within a block are requested in consecutive order, and the last block requests only the pages that remain. A length of zero gives `done` with no request at all.
- R4: The page at index k of a block is given destination block_base + 2048*k. block_base starts at `dest_base` and grows by 131072 after each good block only.
- R5: `rd_req` stays high, with `rd_page` and `rd_dest` held stable, until the cycle in which `rd_ack` is high. Each acknowledge consumes exactly one result.
- R6: A read with `rd_ok`=1 and either `rd_spare[7:0]` (spare byte 0) or `rd_spare[15:8]` (spare byte 1) different from 0xFF marks its block bad. No further page of that block is requested, even if earlier reads in the block failed. The next request is the first page of the following block, which is the block's first page plus 64, and it keeps the same destination base.
- R7: A block in which every read fails is skipped like a marked block, and no error is raised.
- R8: A block that has at least one failed read, at least one successful read and no marker raises `error`. After that, no more requests are made.
- R9: `done` rises once the required number of good blocks has been loaded. `done` and `error` are never high together, and whichever is set stays high until the next `start`.
- R10: A `start` pulse while a load is in progress is ignored.
- R11: The spare bytes that come with a failed read (`rd_ok`=0) are not treated as a marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a load |
| byte_ofs | input | 32 | Byte offset of the image in flash |
| byte_len | input | 32 | Image length in bytes |
| dest_base | input | 32 | Destination address of the first byte |
| rd_req | output | 1 | Page read request |
| rd_page | output | 24 | Flash page number to read |
| rd_dest | output | 32 | Destination address for that page |
| rd_ack | input | 1 | Read result is valid this cycle |
| rd_ok | input | 1 | Read succeeded |
| rd_spare | input | 16 | First two spare-area bytes; byte 0 in bits 7:0 |
| done | output | 1 | Load finished successfully |
| error | output | 1 | Load aborted |

## Verification
The bench aims at these corner cases:

- **Zero-length image and lengths one past a block boundary.** Miscounted rounding shows up here as an extra request, or as a load that never ends.
- **Markers in either spare byte, and a marker that follows a failed read.** A design that classifies these wrongly keeps reading a bad block, or aborts where it should skip.
- **A block with all reads failing, and a single failure in an otherwise good block.** These separate "skip" from "abort". A failed read carrying 0x00 spare bytes would be taken for a bad block if the spare bytes were not qualified by success.
- **A second `start` in the middle of a load.** This exposes a loader that restarts instead of ignoring it.

Random offsets, lengths and outcome maps then compare every request's page and destination against a reference model.

// File: rtl/nand_ldr_pkg.sv
package nand_ldr_pkg;
   typedef enum logic [2:0] {
      LD_IDLE,
      LD_READ,
      LD_CLOSE,
      LD_DONE,
      LD_FAIL
   } ld_state_t;
endpackage

// File: rtl/nand_ldr_span.sv
// Converts a byte offset and length into a first page and page/block counts.
module nand_ldr_span #(
   parameter int LEN_W       = 32,
   parameter int PAGE_W      = 24,
   parameter int PAGE_BYTES  = 2048,
   parameter int BLOCK_PAGES = 64
) (
   input  logic [LEN_W-1:0]  byte_ofs,
   input  logic [LEN_W-1:0]  byte_len,
   output logic [PAGE_W-1:0] first_page,
   output logic [LEN_W:0]    page_cnt,
   output logic [LEN_W:0]    blk_cnt
);
   localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
   localparam int BLK_SHIFT  = PAGE_SHIFT + $clog2(BLOCK_PAGES);
   localparam logic [LEN_W:0] PG_ROUND  = (LEN_W+1)'(PAGE_BYTES - 1);
   localparam logic [LEN_W:0] BLK_ROUND = (LEN_W+1)'(PAGE_BYTES * BLOCK_PAGES - 1);

   generate
      if (PAGE_BYTES != (1 << PAGE_SHIFT)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (BLOCK_PAGES != (1 << $clog2(BLOCK_PAGES))) begin : g_bad_blk
         $error("BLOCK_PAGES must be a power of two");
      end
      if (PAGE_W < LEN_W - PAGE_SHIFT) begin : g_bad_pw
         $error("PAGE_W too narrow for the offset range");
      end
   endgenerate

   logic [LEN_W:0]   len_x;
   logic [LEN_W-1:0] ofs_pages;

   assign len_x      = {1'b0, byte_len};
   assign page_cnt   = (len_x + PG_ROUND)  >> PAGE_SHIFT;
   assign blk_cnt    = (len_x + BLK_ROUND) >> BLK_SHIFT;
   assign ofs_pages  = byte_ofs >> PAGE_SHIFT;
   assign first_page = PAGE_W'(ofs_pages);
endmodule

// File: rtl/nand_ldr_judge.sv
// Per-block tally of read outcomes and bad-block markers.
module nand_ldr_judge #(
   parameter int         MARK_BYTES = 2,
   parameter logic [7:0] ERASED     = 8'hFF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    take,
   input  logic                    ok,
   input  logic [MARK_BYTES*8-1:0] spare,
   output logic                    mark_now,
   output logic                    seen_ok,
   output logic                    seen_fail,
   output logic                    marked
);
   generate
      if (MARK_BYTES < 1) begin : g_bad_mb
         $error("MARK_BYTES must be at least 1");
      end
   endgenerate

   logic [MARK_BYTES-1:0] byte_dirty;

   generate
      for (genvar b = 0; b < MARK_BYTES; b++) begin : g_cmp
         assign byte_dirty[b] = (spare[b*8 +: 8] != ERASED);
      end
   endgenerate

   // spare bytes count only when the read itself succeeded (R11)
   assign mark_now = take && ok && (|byte_dirty);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         seen_ok   <= 1'b0;
         seen_fail <= 1'b0;
         marked    <= 1'b0;
      end else if (take) begin
         if (ok) seen_ok   <= 1'b1;
         else    seen_fail <= 1'b1;
         if (mark_now) marked <= 1'b1;
      end
   end

   assert_mark_needs_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
      marked |-> seen_ok);
   assert_fail_only_on_nok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr && !ok) |=> seen_fail);
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader #(
   parameter int LEN_W       = 32,
   parameter int PAGE_W      = 24,
   parameter int ADDR_W      = 32,
   parameter int PAGE_BYTES  = 2048,
   parameter int BLOCK_PAGES = 64,
   parameter int MARK_BYTES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [LEN_W-1:0]        byte_ofs,
   input  logic [LEN_W-1:0]        byte_len,
   input  logic [ADDR_W-1:0]       dest_base,
   output logic                    rd_req,
   output logic [PAGE_W-1:0]       rd_page,
   output logic [ADDR_W-1:0]       rd_dest,
   input  logic                    rd_ack,
   input  logic                    rd_ok,
   input  logic [MARK_BYTES*8-1:0] rd_spare,
   output logic                    done,
   output logic                    error
);
   import nand_ldr_pkg::*;

   localparam int PAGE_SHIFT  = $clog2(PAGE_BYTES);
   localparam int IDX_W       = $clog2(BLOCK_PAGES) + 1;
   localparam int BLOCK_BYTES = PAGE_BYTES * BLOCK_PAGES;
   localparam logic [LEN_W:0] BLK_PG_L = (LEN_W+1)'(BLOCK_PAGES);

   ld_state_t         state;
   logic [PAGE_W-1:0] page_cur;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] base;
   logic [LEN_W:0]    pages_left, blocks_left;
   logic [IDX_W-1:0]  blk_pages;

   logic [PAGE_W-1:0] first_page;
   logic [LEN_W:0]    page_cnt, blk_cnt;
   logic              take, accept, clr_tally;
   logic              mark_now, seen_ok, seen_fail, marked, bad_blk;

   nand_ldr_span #(
      .LEN_W(LEN_W), .PAGE_W(PAGE_W),
      .PAGE_BYTES(PAGE_BYTES), .BLOCK_PAGES(BLOCK_PAGES)
   ) u_span (
      .byte_ofs(byte_ofs), .byte_len(byte_len),
      .first_page(first_page), .page_cnt(page_cnt), .blk_cnt(blk_cnt)
   );

   nand_ldr_judge #(.MARK_BYTES(MARK_BYTES)) u_judge (
      .clk(clk), .rst_n(rst_n), .clr(clr_tally), .take(take),
      .ok(rd_ok), .spare(rd_spare), .mark_now(mark_now),
      .seen_ok(seen_ok), .seen_fail(seen_fail), .marked(marked)
   );

   // a start is honoured only when no load is running (R10)
   assign accept    = start && (state == LD_IDLE || state == LD_DONE || state == LD_FAIL);
   assign take      = (state == LD_READ) && rd_ack;
   assign clr_tally = accept || (state == LD_CLOSE);
   assign bad_blk   = marked || !seen_ok;   // unreadable counts as bad (R7)

   assign blk_pages = (pages_left < BLK_PG_L) ? IDX_W'(pages_left) : IDX_W'(BLOCK_PAGES);

   assign rd_req  = (state == LD_READ);
   assign rd_page = page_cur + PAGE_W'(idx);
   assign rd_dest = base + (ADDR_W'(idx) << PAGE_SHIFT);
   assign done    = (state == LD_DONE);
   assign error   = (state == LD_FAIL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= LD_IDLE;
         page_cur    <= '0;
         idx         <= '0;
         base        <= '0;
         pages_left  <= '0;
         blocks_left <= '0;
      end else if (accept) begin
         page_cur    <= first_page;
         idx         <= '0;
         base        <= dest_base;
         pages_left  <= page_cnt;
         blocks_left <= blk_cnt;
         state       <= (blk_cnt == '0) ? LD_DONE : LD_READ;
      end else begin
         unique case (state)
            LD_READ: begin
               if (take) begin
                  idx <= idx + 1'b1;
                  if (mark_now || (idx + 1'b1 == blk_pages)) state <= LD_CLOSE;
               end
            end
            LD_CLOSE: begin
               idx <= '0;
               if (seen_fail && !bad_blk) begin
                  state <= LD_FAIL;
               end else begin
                  page_cur <= page_cur + PAGE_W'(BLOCK_PAGES);
                  if (!bad_blk) begin
                     base        <= base + ADDR_W'(BLOCK_BYTES);
                     pages_left  <= pages_left - (LEN_W+1)'(blk_pages);
                     blocks_left <= blocks_left - 1'b1;
                     state       <= (blocks_left == (LEN_W+1)'(1)) ? LD_DONE : LD_READ;
                  end else begin
                     state <= LD_READ;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack && !start) |=> (rd_req && $stable(rd_page) && $stable(rd_dest)));
   assert_idx_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (idx < blk_pages));
   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   assert_error_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |=> error);
   assert_quiet_when_finished_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !rd_req);
   assert_marker_ends_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mark_now) |=> !rd_req);
endmodule

// File: tb/nand_image_loader_test.sv
`timescale 1ns/1ps
module nand_image_loader_test;
   localparam int MAXE = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] byte_ofs = '0, byte_len = '0, dest_base = '0;
   logic        rd_req, rd_ack, rd_ok, done, error;
   logic [23:0] rd_page;
   logic [31:0] rd_dest;
   logic [15:0] rd_spare;

   always #2 clk = ~clk;

   nand_image_loader uut (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_ofs(byte_ofs),
      .byte_len(byte_len), .dest_base(dest_base), .rd_req(rd_req),
      .rd_page(rd_page), .rd_dest(rd_dest), .rd_ack(rd_ack), .rd_ok(rd_ok),
      .rd_spare(rd_spare), .done(done), .error(error)
   );

   int n_checks = 0, n_errs = 0;
   int oc [MAXE];           // 0 ok, 1 fail, 2 marker byte0, 3 marker byte1
   int exp_page [MAXE];
   logic [31:0] exp_dest [MAXE];
   int exp_n;
   bit exp_err;
   int got_page [MAXE];
   logic [31:0] got_dest [MAXE];
   int got_n = 0;
   int cur_sp0 = 0;

   task automatic chk(input bit cond, input string req, input longint act, input longint expv);
      n_checks++;
      if (!cond) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   // page-read engine model
   initial begin : responder
      rd_ack = 1'b0;
      rd_ok = 1'b0;
      rd_spare = 16'hFFFF;
      forever begin
         @(negedge clk);
         rd_ack = 1'b0;
         if (rd_req) begin
            int pg, dly, k, c;
            logic [31:0] ds;
            pg = int'(rd_page);
            ds = rd_dest;
            if (got_n < MAXE) begin
               got_page[got_n] = pg;
               got_dest[got_n] = ds;
            end
            got_n++;
            dly = $urandom_range(0, 2);
            for (int d = 0; d < dly; d++) begin
               @(negedge clk);
               chk(rd_req && int'(rd_page) == pg && rd_dest == ds, "R5 hold", int'(rd_page), pg);
            end
            k = pg - cur_sp0;
            c = (k >= 0 && k < MAXE) ? oc[k] : 0;
            case (c)
               1: begin rd_ok = 1'b0; rd_spare = 16'h0000; end   // R11 stimulus
               2: begin rd_ok = 1'b1; rd_spare = 16'hFF00; end
               3: begin rd_ok = 1'b1; rd_spare = 16'h5AFF; end
               default: begin rd_ok = 1'b1; rd_spare = 16'hFFFF; end
            endcase
            rd_ack = 1'b1;
         end
      end
   end

   task automatic clear_oc();
      for (int i = 0; i < MAXE; i++) oc[i] = 0;
   endtask

   task automatic build_expected(input int offs, input int len, input logic [31:0] base,
                                 output bit runnable);
      int sp, pl, bl, r, nblk, bp, good, bad, err, k, c;
      logic [31:0] b;
      sp = offs >> 11;
      pl = (len + 2047) / 2048;
      bl = (len + 131071) / 131072;
      b = base; r = 0; nblk = 0; exp_n = 0; exp_err = 0; runnable = 1;
      while (bl > 0) begin
         if (nblk == 60) begin runnable = 0; return; end
         bp = (pl < 64) ? pl : 64;
         good = 0; bad = 0; err = 0; k = 0;
         while (k < bp && bad == 0) begin
            exp_page[exp_n] = sp + r + k;
            exp_dest[exp_n] = b + 32'(2048 * k);
            exp_n++;
            c = oc[r + k];
            if (c == 1) err++;
            else begin
               good++;
               if (c >= 2) bad++;
            end
            k++;
         end
         if (good == 0) bad = err;
         if (err > 0 && bad == 0) begin exp_err = 1; break; end
         if (bad == 0) begin b = b + 32'd131072; pl -= bp; bl--; end
         r += 64;
         nblk++;
      end
   endtask

   task automatic run_case(input int offs, input int len, input logic [31:0] base,
                           input bit restart, input string tag);
      bit runnable;
      int t, lim;
      build_expected(offs, len, base, runnable);
      if (!runnable) return;
      @(negedge clk);
      cur_sp0 = offs >> 11;
      got_n = 0;
      byte_ofs = 32'(offs); byte_len = 32'(len); dest_base = base;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         repeat (5) @(negedge clk);
         byte_ofs = 32'd0; byte_len = 32'd1; dest_base = 32'hDEAD0000;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (!(done || error) && t < 30000) begin @(negedge clk); t++; end
      chk(t < 30000, {tag, " finish"}, t, 0);
      chk(error == exp_err, {tag, " R8 error flag"}, error, exp_err);
      chk(done == !exp_err, {tag, " R9 done flag"}, done, !exp_err);
      chk(got_n == exp_n, {tag, " R3 request count"}, got_n, exp_n);
      lim = (got_n < exp_n) ? got_n : exp_n;
      for (int i = 0; i < lim; i++) begin
         chk(got_page[i] == exp_page[i], {tag, " R2 R6 page"}, got_page[i], exp_page[i]);
         chk(got_dest[i] == exp_dest[i], {tag, " R4 dest"}, got_dest[i], exp_dest[i]);
      end
      repeat (3) @(negedge clk);
      chk(done == !exp_err && error == exp_err, {tag, " R9 flags held"}, {done, error}, {!exp_err, exp_err});
      chk(!rd_req, {tag, " R8 no request after finish"}, rd_req, 0);
   endtask

   initial begin : main
      void'($urandom(32'h5EED1234));
      clear_oc();
      repeat (3) @(negedge clk);
      chk(!rd_req && !done && !error, "R1 reset outputs", {rd_req, done, error}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_req && !done && !error, "R1 idle after reset", {rd_req, done, error}, 0);

      // R3 zero length
      run_case(4096, 0, 32'h1000_0000, 0, "zero_len");
      // R2 sub-page offset, one byte
      run_case(5000, 1, 32'h2000_0000, 0, "one_byte");
      // R3 one page past a block
      run_case(0, 131073, 32'h3000_0000, 0, "blk_plus1");
      // R6 marker in byte 0 at page 3
      clear_oc(); oc[3] = 2;
      run_case(2048 * 7, 131072, 32'h4000_0000, 0, "mark_b0");
      // R6 marker in byte 1 at page 0
      clear_oc(); oc[0] = 3;
      run_case(0, 4096, 32'h4100_0000, 0, "mark_b1");
      // R7 whole block unreadable
      clear_oc(); for (int i = 0; i < 64; i++) oc[i] = 1;
      run_case(0, 6000, 32'h5000_0000, 0, "all_fail");
      // R8 and R11 one failure in a good block (spare 0x00 on the failure)
      clear_oc(); oc[5] = 1;
      run_case(0, 131072 * 2, 32'h6000_0000, 0, "single_fail");
      // R6 failure followed by marker: skipped, not an error
      clear_oc(); oc[2] = 1; oc[9] = 2;
      run_case(0, 20000, 32'h7000_0000, 0, "fail_then_mark");
      // R10 restart while busy is ignored
      clear_oc(); oc[70] = 3;
      run_case(2048, 131072 + 4096, 32'h8000_0000, 1, "restart_busy");

      // random mix
      for (int n = 0; n < 16; n++) begin
         int offs, len;
         logic [31:0] base;
         clear_oc();
         for (int i = 0; i < MAXE; i++) begin
            int r;
            r = $urandom_range(0, 399);
            oc[i] = (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 3 : 0;
         end
         if (n % 4 == 3)
            for (int i = 64; i < 128; i++) oc[i] = 1;
         offs = $urandom_range(0, 1 << 20);
         len  = $urandom_range(1, 3 * 131072);
         base = $urandom;
         run_case(offs, len, base, 0, "random");
      end
      finish_run();
   end
endmodule